// File: doc/BRIEF.md
# 128-bit Vector Permute and Byte-Shift Unit

This block rearranges data inside a 128-bit integer vector. It takes two 128-bit operands, an 8-bit immediate and a 4-bit operation code. One clock edge after a valid input it presents the registered result with a matching valid strobe. The operations are word shuffles confined to one 64-bit half, a doubleword shuffle across the whole vector, whole-register byte shifts in either direction, interleaves of the two upper or the two lower quadwords, and two moves between a 64-bit quadword and the vector.

Shuffles take their data from the second operand. Each 2-bit field of the immediate picks one source lane for one destination lane. Byte shifts act on the first operand and use the immediate as a byte count. Operands arrive already loaded. The unit has no memory access and no register file.

Top module: `simd_permute_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result`, `out_valid` and `op_illegal` are cleared to zero at that edge.
- R2: `out_valid` is high in the cycle after an edge where `in_valid` was high, and low in the cycle after an edge where it was low.
- R3: When `in_valid` is low at an edge, `result` and `op_illegal` keep their previous values.
- R4: Op code 0 (high word shuffle): result word k+4, for k = 0..3, is 16-bit word imm[2k+1:2k] of `src_b[127:64]`. Result bits 63..0 equal `src_b[63:0]`. A source word may feed several destination words.
- R5: Op code 1 (low word shuffle): result word k, for k = 0..3, is 16-bit word imm[2k+1:2k] of `src_b[63:0]`. Result bits 127..64 equal `src_b[127:64]`.
- R6: Op code 2 (doubleword shuffle): result doubleword k is 32-bit doubleword imm[2k+1:2k] of `src_b`. Repeated selectors are allowed.
- R7: Op code 3 (byte shift left): for a count of 15 or less, the result is `src_a` shifted left by imm×8 bits, with the vacated low bytes set to zero.
- R8: Op code 4 (byte shift right): for a count of 15 or less, the result is `src_a` shifted right by imm×8 bits, with the vacated high bytes set to zero.
- R9: For op codes 3 and 4, any immediate above 15 gives an all-zero result.
- R10: Op code 5 (high interleave): result[63:0] = `src_a[127:64]` and result[127:64] = `src_b[127:64]`.
- R11: Op code 6 (low interleave): result[63:0] = `src_a[63:0]` and result[127:64] = `src_b[63:0]`.
- R12: Op code 7 (quadword into vector): result = {64 zeros, `src_b[63:0]`}. Op code 8 (low quadword out): result = {64 zeros, `src_a[63:0]`}.
- R13: Op codes 9 to 15 give an all-zero result with `op_illegal` high in the same cycle as `out_valid`. Op codes 0 to 8 give `op_illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| op | input | 4 | Operation code |
| imm | input | 8 | Lane selectors or byte count |
| src_a | input | 128 | First operand |
| src_b | input | 128 | Second operand |
| out_valid | output | 1 | Result is valid |
| result | output | 128 | Registered result |
| op_illegal | output | 1 | Unused op code was presented |

## Verification
Shuffles are tried with the identity selector, the reversing selector, an all-same selector and a repeated-same selector. A wrong field-to-lane mapping or lost duplication of a source lane shows up against those patterns. Byte shifts are driven with counts 0, 1, 15, 16 and 255, which separates an ordinary shift from the saturation edge and the wrap of a truncated count. Random operands with random op codes and immediates then cover the rest, including every illegal code. An idle cycle follows every operation to show that the output holds its value.

// File: rtl/simd_permute_unit.sv
module simd_permute_unit #(
  parameter int OPW  = 4,
  parameter int IMMW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OPW-1:0]  op,
  input  logic [IMMW-1:0] imm,
  input  logic [127:0]    src_a,
  input  logic [127:0]    src_b,
  output logic            out_valid,
  output logic [127:0]    result,
  output logic            op_illegal
);
  localparam logic [OPW-1:0] OP_SHUF_HI = OPW'(0);
  localparam logic [OPW-1:0] OP_SHUF_LO = OPW'(1);
  localparam logic [OPW-1:0] OP_SHUF_DW = OPW'(2);
  localparam logic [OPW-1:0] OP_BSHL    = OPW'(3);
  localparam logic [OPW-1:0] OP_BSHR    = OPW'(4);
  localparam logic [OPW-1:0] OP_ILV_HI  = OPW'(5);
  localparam logic [OPW-1:0] OP_ILV_LO  = OPW'(6);
  localparam logic [OPW-1:0] OP_Q2V     = OPW'(7);
  localparam logic [OPW-1:0] OP_V2Q     = OPW'(8);

  function automatic logic [15:0] pick_w(input logic [63:0] q, input logic [1:0] s);
    return q[s*16 +: 16];
  endfunction

  function automatic logic [31:0] pick_d(input logic [127:0] v, input logic [1:0] s);
    return v[s*32 +: 32];
  endfunction

  function automatic logic [63:0] shuf_q(input logic [63:0] q, input logic [7:0] sel);
    return {pick_w(q, sel[7:6]), pick_w(q, sel[5:4]), pick_w(q, sel[3:2]), pick_w(q, sel[1:0])};
  endfunction

  logic [7:0]   sel;
  logic         big_cnt;
  logic [7:0]   bit_cnt;
  logic [127:0] nxt;
  logic         nxt_bad;

  assign sel     = imm[7:0];
  assign big_cnt = imm > IMMW'(15);
  assign bit_cnt = big_cnt ? 8'd128 : {1'b0, imm[3:0], 3'b000};

  always_comb begin
    nxt     = '0;
    nxt_bad = 1'b0;
    case (op)
      OP_SHUF_HI: nxt = {shuf_q(src_b[127:64], sel), src_b[63:0]};
      OP_SHUF_LO: nxt = {src_b[127:64], shuf_q(src_b[63:0], sel)};
      OP_SHUF_DW: nxt = {pick_d(src_b, sel[7:6]), pick_d(src_b, sel[5:4]),
                         pick_d(src_b, sel[3:2]), pick_d(src_b, sel[1:0])};
      OP_BSHL:    nxt = src_a << bit_cnt;
      OP_BSHR:    nxt = src_a >> bit_cnt;
      OP_ILV_HI:  nxt = {src_b[127:64], src_a[127:64]};
      OP_ILV_LO:  nxt = {src_b[63:0], src_a[63:0]};
      OP_Q2V:     nxt = {64'd0, src_b[63:0]};
      OP_V2Q:     nxt = {64'd0, src_a[63:0]};
      default:    nxt_bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      result     <= '0;
      op_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= nxt;
        op_illegal <= nxt_bad;
      end
    end
  end
endmodule

// File: rtl/simd_permute_unit_chk.sv
module simd_permute_unit_chk #(
  parameter int OPW  = 4,
  parameter int IMMW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [OPW-1:0]  op,
  input logic [IMMW-1:0] imm,
  input logic            out_valid,
  input logic [127:0]    result,
  input logic            op_illegal
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !op_illegal));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(op_illegal)));

  a_r9_big_count_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OPW'(3) || op == OPW'(4)) && imm > IMMW'(15)) |=> result == '0);

  a_r12_upper_cleared: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OPW'(7) || op == OPW'(8))) |=> result[127:64] == 64'd0);

  a_r13_illegal_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op > OPW'(8)) |=> (op_illegal && out_valid && result == '0));

  a_r13_legal_no_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op <= OPW'(8)) |=> !op_illegal);
endmodule

bind simd_permute_unit simd_permute_unit_chk #(.OPW(OPW), .IMMW(IMMW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .imm(imm),
  .out_valid(out_valid), .result(result), .op_illegal(op_illegal)
);

// File: tb/simd_permute_unit_tb_top.sv
module simd_permute_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   op = '0;
  logic [7:0]   imm = '0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic         out_valid;
  logic [127:0] result;
  logic         op_illegal;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  simd_permute_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .imm(imm),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .result(result), .op_illegal(op_illegal)
  );

  function automatic logic [128:0] model(input int o, input int im,
                                         input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = '0;
    logic ill = 1'b0;
    int n = (im > 15) ? 16 : im;
    case (o)
      0: begin
        r[63:0] = b[63:0];
        for (int k = 0; k < 4; k++) r[64+16*k +: 16] = b[64+16*((im >> (2*k)) & 3) +: 16];
      end
      1: begin
        r[127:64] = b[127:64];
        for (int k = 0; k < 4; k++) r[16*k +: 16] = b[16*((im >> (2*k)) & 3) +: 16];
      end
      2: for (int k = 0; k < 4; k++) r[32*k +: 32] = b[32*((im >> (2*k)) & 3) +: 32];
      3: for (int i = 0; i < 16; i++) if (i >= n) r[8*i +: 8] = a[8*(i-n) +: 8];
      4: for (int i = 0; i < 16; i++) if (i + n < 16) r[8*i +: 8] = a[8*(i+n) +: 8];
      5: r = {b[127:64], a[127:64]};
      6: r = {b[63:0], a[63:0]};
      7: r = {64'd0, b[63:0]};
      8: r = {64'd0, a[63:0]};
      default: ill = 1'b1;
    endcase
    return {ill, r};
  endfunction

  function automatic string tag_of(input int o, input int im);
    case (o)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return (im > 15) ? "R9" : "R7";
      4: return (im > 15) ? "R9" : "R8";
      5: return "R10";
      6: return "R11";
      7, 8: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input int o, input int im, input logic [127:0] a, input logic [127:0] b);
    logic [128:0] e;
    logic [127:0] held;
    e = model(o, im, a, b);
    @(negedge clk);
    op = o[3:0]; imm = im[7:0]; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    src_a = ~a; src_b = ~b; op = 4'(o + 1); imm = ~im[7:0];
    chk("R2 valid", {127'd0, out_valid}, 128'd1);
    chk(tag_of(o, im), result, e[127:0]);
    chk("R13 flag", {127'd0, op_illegal}, {127'd0, e[128]});
    held = result;
    @(negedge clk);
    chk("R2 idle", {127'd0, out_valid}, 128'd0);
    chk("R3 hold", result, held);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] pa;
    logic [127:0] pb;
    void'($urandom(32'd20240611));
    pa = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
    pb = 128'h77776666_55554444_33332222_11110000;
    repeat (3) @(negedge clk);
    chk("R1 result", result, 128'd0);
    chk("R1 valid", {127'd0, out_valid}, 128'd0);
    chk("R1 flag", {127'd0, op_illegal}, 128'd0);
    rst = 1'b0;

    foreach (pa[i]) begin end
    for (int o = 0; o < 3; o++) begin
      run_op(o, 8'hE4, pa, pb);
      run_op(o, 8'h1B, pa, pb);
      run_op(o, 8'h00, pa, pb);
      run_op(o, 8'hFF, pa, pb);
      run_op(o, 8'h5A, pa, pb);
    end
    for (int o = 3; o < 5; o++) begin
      run_op(o, 0, pa, pb);
      run_op(o, 1, pa, pb);
      run_op(o, 15, pa, pb);
      run_op(o, 16, pa, pb);
      run_op(o, 255, pa, pb);
    end
    for (int o = 5; o < 16; o++) run_op(o, 8'h33, pa, pb);

    for (int t = 0; t < 600; t++) begin
      int o = $urandom_range(0, 15);
      int im = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 17);
      run_op(o, im, rnd128(), rnd128());
    end

    @(negedge clk);
    in_valid = 1'b1; op = 4'd2; imm = 8'h1B; src_a = pa; src_b = pb;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk("R1 result after run", result, 128'd0);
    chk("R1 valid after run", {127'd0, out_valid}, 128'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule